// File: doc/BRIEF.md
# SPI EEPROM Page-Write Controller

This block is an SPI master for a serial EEPROM that has a 16-bit address. A client starts a request with a single-cycle pulse. The request gives a direction, a start address and a byte count of 0 to 255. The client then watches `req_busy` and `req_done`. Write data is taken from `wr_data` one byte at a time, and each byte taken is marked by `wr_take`. Read data is returned on `rd_data` and qualified by `rd_valid`.

The controller builds every SPI frame on the bus itself. A status-poll frame sends opcode 0x05 and shifts in one reply byte while sending 0x00. Bit 0 of that reply is the device's write-in-progress flag. A write-enable frame is the single byte 0x06. A page-write frame sends 0x02, then the address high byte, then the address low byte, then the data. A read frame sends 0x03, the same two address bytes, and one 0x00 dummy byte for each byte read. A long write is split into several page-write frames wherever the address crosses a 16-byte boundary. Each of those frames is preceded by a status poll and a write-enable frame. After reset the block sends one write-disable frame, the single byte 0x04.

The serial clock runs in SPI mode 0 at the system clock divided by `SCK_DIV`.

Top module: `spi_eeprom_pager`

## Requirements
- R1: After reset, `cs_n` is high and `sclk` is low, and `req_busy` stays high. The first frame sent is the single byte 0x04. After it, `req_busy` falls.
- R2: Serial timing is mode 0. `sclk` idles low and is high for `SCK_DIV/2` system cycles per pulse (8 by default). MOSI is shifted MSB first and MISO is sampled on the rising edge.
- R3: A read of N bytes is one frame of length N+3: 0x03, the address high byte, the address low byte, then N dummy bytes. The N returned bytes appear in order, each on a one-cycle `rd_valid` pulse. A read sends no status poll.
- R4: Before every page-write frame, the block sends status-poll frames of two bytes each (0x05, 0x00). It repeats the poll until bit 0 of the reply byte is 0.
- R5: Every page-write frame is directly preceded by a write-enable frame that contains only 0x06.
- R6: A page-write frame is 0x02, the address high byte, the address low byte, then the data. `wr_take` pulses once for each data byte, while `cs_n` is low.
- R7: A write frame ends after any byte whose next address has its low 4 bits equal to 0, if bytes remain. The next frame (after its poll and write-enable) restarts at that new address.
- R8: The address increment wraps from 0xFFFF to 0x0000.
- R9: A request with a count of 0 produces no SPI frame. `req_done` is high in the cycle after the start pulse.
- R10: `req_busy` rises the cycle after an accepted start and stays high until the last `cs_n` release. `req_done` is a one-cycle pulse while `req_busy` is high.
- R11: `sclk` never toggles while `cs_n` is high, and `cs_n` is high whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Single-cycle request pulse, accepted when not busy |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | Start address |
| req_len | input | 8 | Byte count, 0 to 255 |
| req_busy | output | 1 | Request or boot sequence in progress |
| req_done | output | 1 | One-cycle completion pulse |
| wr_data | input | 8 | Next write byte; must be valid while `wr_take` is high |
| wr_take | output | 1 | `wr_data` is consumed at this clock edge |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |
| cs_n | output | 1 | Active-low chip select |

## Verification
A corrupted sequencer state is visible on the bus within one frame. The symptom is a frame with the wrong opcode or length, a missing poll or write-enable frame, or a page-write frame that starts at the wrong address. A bench-side device model records every frame and returns write-in-progress for two polls after each page write. That model makes a skipped poll loop or a page split at the wrong place visible as soon as the next frame opens. A broken shift engine corrupts the address bytes or the read data in the same byte where the fault occurs. A broken handshake shows up as a missing or stretched `req_done`.

// File: rtl/spi_eeprom_pager.sv
module spi_eeprom_pager #(
  parameter int SCK_DIV    = 16,
  parameter int PAGE_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_len,
  output logic        req_busy,
  output logic        req_done,
  input  logic [7:0]  wr_data,
  output logic        wr_take,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int HALF = SCK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int GW   = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
  localparam int PW   = $clog2(PAGE_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_FIN, S_WRDI, S_POLL_OP, S_POLL_RD, S_WREN,
    S_WR_OP, S_WR_AH, S_WR_AL, S_WR_DATA, S_RD_OP, S_RD_AH, S_RD_AL, S_RD_DATA
  } st_t;

  st_t         st, gap_next;
  logic [GW-1:0] gcnt;
  logic        armed;
  logic [15:0] addr;
  logic [7:0]  cnt;

  logic          bx_busy, bx_done, rbit;
  logic [DW-1:0] dcnt;
  logic [2:0]    bcnt;
  logic [7:0]    sh, tx_sel;

  logic        in_byte, launch;
  logic [15:0] nxt_addr;

  assign in_byte  = !(st inside {S_IDLE, S_GAP, S_FIN});
  assign launch   = in_byte && !armed;
  assign cs_n     = !in_byte;
  assign mosi     = sh[7];
  assign rd_data  = sh;
  assign req_busy = (st != S_IDLE);
  assign req_done = (st == S_FIN);
  assign wr_take  = launch && (st == S_WR_DATA);
  assign nxt_addr = addr + 16'd1;

  always_comb begin
    case (st)
      S_WRDI:    tx_sel = 8'h04;
      S_POLL_OP: tx_sel = 8'h05;
      S_WREN:    tx_sel = 8'h06;
      S_WR_OP:   tx_sel = 8'h02;
      S_RD_OP:   tx_sel = 8'h03;
      S_WR_AH, S_RD_AH: tx_sel = addr[15:8];
      S_WR_AL, S_RD_AL: tx_sel = addr[7:0];
      S_WR_DATA: tx_sel = wr_data;
      default:   tx_sel = 8'h00;
    endcase
  end

  // byte exchange engine, mode 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_busy <= 1'b0;
      bx_done <= 1'b0;
      sclk    <= 1'b0;
      dcnt    <= '0;
      bcnt    <= '0;
      sh      <= '0;
      rbit    <= 1'b0;
    end else begin
      bx_done <= 1'b0;
      if (launch) begin
        bx_busy <= 1'b1;
        sh      <= tx_sel;
        dcnt    <= '0;
        bcnt    <= '0;
      end else if (bx_busy) begin
        if (dcnt == DW'(HALF - 1)) begin
          dcnt <= '0;
          sclk <= !sclk;
          if (!sclk) begin
            rbit <= miso;
          end else begin
            sh   <= {sh[6:0], rbit};
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              bx_busy <= 1'b0;
              bx_done <= 1'b1;
            end
          end
        end else begin
          dcnt <= dcnt + DW'(1);
        end
      end
    end
  end

  // frame sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_GAP;
      gap_next <= S_WRDI;
      gcnt     <= '0;
      armed    <= 1'b0;
      addr     <= '0;
      cnt      <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= bx_done && (st == S_RD_DATA);
      if (launch) armed <= 1'b1;
      case (st)
        S_IDLE: if (req_start) begin
          addr <= req_addr;
          cnt  <= req_len;
          if (req_len == 8'd0) st <= S_FIN;
          else if (req_write)  st <= S_POLL_OP;
          else                 st <= S_RD_OP;
        end
        S_GAP: begin
          if (gcnt == GW'(SCK_DIV - 1)) begin
            gcnt <= '0;
            st   <= gap_next;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
        S_FIN: st <= S_IDLE;
        default: if (bx_done) begin
          armed <= 1'b0;
          case (st)
            S_WRDI:    begin st <= S_GAP; gap_next <= S_IDLE; end
            S_POLL_OP: st <= S_POLL_RD;
            S_POLL_RD: begin st <= S_GAP; gap_next <= sh[0] ? S_POLL_OP : S_WREN; end
            S_WREN:    begin st <= S_GAP; gap_next <= S_WR_OP; end
            S_WR_OP:   st <= S_WR_AH;
            S_WR_AH:   st <= S_WR_AL;
            S_WR_AL:   st <= S_WR_DATA;
            S_RD_OP:   st <= S_RD_AH;
            S_RD_AH:   st <= S_RD_AL;
            S_RD_AL:   st <= S_RD_DATA;
            S_WR_DATA: begin
              addr <= nxt_addr;
              cnt  <= cnt - 8'd1;
              if (cnt == 8'd1) begin
                st <= S_GAP; gap_next <= S_FIN;
              end else if (nxt_addr[PW-1:0] == '0) begin
                st <= S_GAP; gap_next <= S_POLL_OP;
              end
            end
            S_RD_DATA: begin
              cnt <= cnt - 8'd1;
              if (cnt == 8'd1) begin
                st <= S_GAP; gap_next <= S_FIN;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      endcase
    end
  end
endmodule

module spi_eeprom_pager_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_start,
  input logic [7:0] req_len,
  input logic       req_busy,
  input logic       req_done,
  input logic       wr_take,
  input logic       rd_valid,
  input logic       sclk,
  input logic       cs_n
);
  p_sclk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_cs_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_busy |-> cs_n);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);
  p_done_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> req_busy);
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !req_busy && req_len != 8'd0) |=> (req_busy && !req_done));
  p_take_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !cs_n);
  p_rd_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> req_busy);
endmodule

bind spi_eeprom_pager spi_eeprom_pager_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_len(req_len),
  .req_busy(req_busy), .req_done(req_done), .wr_take(wr_take),
  .rd_valid(rd_valid), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/tb_spi_eeprom_pager.sv
`timescale 1ns/1ps
module tb_spi_eeprom_pager;
  logic clk = 0, rst_n = 0;
  logic req_start = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_len = 0, wr_data = 0;
  logic req_busy, req_done, wr_take, rd_valid, sclk, mosi, miso = 0, cs_n;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  spi_eeprom_pager dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_busy(req_busy), .req_done(req_done),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  int n_chk = 0, n_fail = 0;

  // device model
  logic [7:0] mem [256];
  logic [7:0] fb [3];
  logic [7:0] log_op [64];
  int         log_len [64];
  logic [15:0] log_addr [64];
  int nl = 0, nb = 0, sbit = 0, wip = 0, bad_wel = 0;
  logic wel = 0, pcs = 1, psck = 0;
  logic [7:0] rsh = 0, txsh = 0;
  logic [15:0] waddr = 0, raddr = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(sclk or cs_n) begin
    if (cs_n === 1'b0 && pcs === 1'b1) begin
      nb = 0; sbit = 0; txsh = 0; fb[0] = 0; fb[1] = 0; fb[2] = 0;
    end else if (cs_n === 1'b1 && pcs === 1'b0) begin
      if (nl < 64) begin
        log_op[nl] = fb[0]; log_len[nl] = nb; log_addr[nl] = {fb[1], fb[2]};
      end
      nl++;
      case (fb[0])
        8'h06: wel = 1;
        8'h04: wel = 0;
        8'h02: begin if (!wel) bad_wel++; wel = 0; wip = 2; end
        8'h05: if (wip > 0) wip--;
        default: ;
      endcase
    end
    pcs = cs_n;
    if (sclk !== psck && cs_n === 1'b0) begin
      if (sclk === 1'b1) begin
        rsh = {rsh[6:0], mosi};
        sbit++;
        if (sbit == 8) begin
          sbit = 0;
          if (nb < 3) fb[nb] = rsh;
          if (fb[0] == 8'h02 && nb == 2) waddr = {fb[1], rsh};
          if (fb[0] == 8'h02 && nb >= 3) begin mem[waddr[7:0]] = rsh; waddr++; end
          if (fb[0] == 8'h03 && nb == 2) raddr = {fb[1], rsh};
          if (fb[0] == 8'h05 && nb == 0) txsh = {6'b0, wel, wip > 0};
          if (fb[0] == 8'h03 && nb >= 2) begin txsh = mem[raddr[7:0]]; raddr++; end
          nb++;
        end
      end else begin
        miso = txsh[7];
        txsh = {txsh[6:0], 1'b0};
      end
    end
    psck = sclk;
  end

  // write data source, read capture, sclk high-time monitor
  logic [7:0] wbuf [16];
  logic [7:0] rd_buf [16];
  int wr_ptr = 0, rd_n = 0, hi_run = 0, last_hi = 0;
  bit take_pend = 0;
  always @(negedge clk) begin
    if (req_start) begin wr_ptr = 0; rd_n = 0; end
    else if (take_pend) wr_ptr++;
    take_pend = wr_take;
    wr_data = wbuf[wr_ptr % 16];
    if (rd_valid && rd_n < 16) begin rd_buf[rd_n] = rd_data; rd_n++; end
    if (sclk) hi_run++;
    else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic exp_fr(input int i, input logic [7:0] op, input int len,
                        input logic [15:0] a, input string tag);
    chk(log_op[i] == op, tag, int'(log_op[i]), int'(op));
    chk(log_len[i] == len, tag, log_len[i], len);
    if (len >= 3) chk(log_addr[i] == a, tag, int'(log_addr[i]), int'(a));
  endtask

  int last_cyc;
  task automatic run(input bit w, input logic [15:0] a, input int n);
    int cyc = 0;
    @(negedge clk);
    req_write = w; req_addr = a; req_len = 8'(n); req_start = 1;
    @(negedge clk);
    req_start = 0;
    if (n != 0) chk(req_busy && !req_done, "R10 busy after start", int'(req_busy), 1);
    while (!req_done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(req_done === 1'b1, "R10 done", int'(req_done), 1);
    chk(cs_n === 1'b1, "R10 cs released at done", int'(cs_n), 1);
    @(negedge clk);
    chk(!req_done && !req_busy, "R10 done one cycle", int'({req_done, req_busy}), 0);
    last_cyc = cyc;
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 reset pins", int'({cs_n, sclk}), 2);
    rst_n = 1;
    @(negedge clk);
    chk(req_busy === 1'b1, "R1 busy during boot", int'(req_busy), 1);
    for (int c = 0; c < 2000 && req_busy; c++) @(negedge clk);
    chk(!req_busy, "R1 boot ends", int'(req_busy), 0);
    chk(nl == 1, "R1 one boot frame", nl, 1);
    exp_fr(0, 8'h04, 1, 0, "R1 write-disable frame");
  endtask

  task automatic t_read;
    int b = nl;
    run(0, 16'h0120, 3);
    chk(nl == b + 1, "R3 single frame, no poll", nl - b, 1);
    exp_fr(b, 8'h03, 6, 16'h0120, "R3 read frame");
    chk(rd_n == 3, "R3 byte count", rd_n, 3);
    for (int i = 0; i < 3; i++)
      chk(rd_buf[i] == (8'(8'h20 + i) ^ 8'h5A), "R3 read data", int'(rd_buf[i]),
          int'(8'(8'h20 + i) ^ 8'h5A));
    chk(last_hi == 8, "R2 sclk high time", last_hi, 8);
  endtask

  task automatic t_write_in_page;
    int b = nl;
    for (int i = 0; i < 16; i++) wbuf[i] = 8'hA0 + 8'(i);
    run(1, 16'h0042, 4);
    chk(nl == b + 3, "R4 frame count", nl - b, 3);
    exp_fr(b, 8'h05, 2, 0, "R4 status poll");
    exp_fr(b + 1, 8'h06, 1, 0, "R5 write enable");
    exp_fr(b + 2, 8'h02, 7, 16'h0042, "R6 write frame");
    for (int i = 0; i < 4; i++)
      chk(mem[8'h42 + i] == 8'hA0 + 8'(i), "R6 data", int'(mem[8'h42 + i]), 8'hA0 + i);
    chk(bad_wel == 0, "R5 latch set before write", bad_wel, 0);
  endtask

  task automatic t_write_cross;
    int b = nl;
    for (int i = 0; i < 16; i++) wbuf[i] = 8'hC0 + 8'(i);
    run(1, 16'h003E, 5);
    chk(nl == b + 10, "R7 frame count", nl - b, 10);
    for (int i = 0; i < 3; i++) exp_fr(b + i, 8'h05, 2, 0, "R4 repeated poll");
    exp_fr(b + 3, 8'h06, 1, 0, "R5 enable page 1");
    exp_fr(b + 4, 8'h02, 5, 16'h003E, "R7 first page");
    for (int i = 5; i < 8; i++) exp_fr(b + i, 8'h05, 2, 0, "R4 poll between pages");
    exp_fr(b + 8, 8'h06, 1, 0, "R5 enable page 2");
    exp_fr(b + 9, 8'h02, 6, 16'h0040, "R7 second page");
    for (int i = 0; i < 5; i++)
      chk(mem[8'h3E + i] == 8'hC0 + 8'(i), "R7 data", int'(mem[8'h3E + i]), 8'hC0 + i);
    chk(bad_wel == 0, "R5 latch set before each page", bad_wel, 0);
  endtask

  task automatic t_zero;
    int b = nl;
    run(1, 16'h0010, 0);
    chk(last_cyc == 0, "R9 immediate done", last_cyc, 0);
    chk(nl == b, "R9 no frame", nl - b, 0);
  endtask

  task automatic t_wrap;
    int b = nl;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    run(1, 16'hFFFF, 2);
    chk(nl == b + 10, "R8 frame count", nl - b, 10);
    exp_fr(b + 4, 8'h02, 4, 16'hFFFF, "R8 last address");
    exp_fr(b + 9, 8'h02, 4, 16'h0000, "R8 wrapped address");
    chk(mem[8'hFF] == 8'h11, "R8 data at top", int'(mem[8'hFF]), 8'h11);
    chk(mem[8'h00] == 8'h22, "R8 data at zero", int'(mem[8'h00]), 8'h22);
  endtask

  task automatic t_readback;
    int b = nl;
    run(0, 16'h003F, 3);
    exp_fr(b, 8'h03, 6, 16'h003F, "R3 readback frame");
    chk(rd_buf[0] == 8'hC1, "R3 readback 0", int'(rd_buf[0]), 8'hC1);
    chk(rd_buf[1] == 8'hC2, "R3 readback 1", int'(rd_buf[1]), 8'hC2);
    chk(rd_buf[2] == 8'hC3, "R3 readback 2", int'(rd_buf[2]), 8'hC3);
  endtask

  initial begin
    t_reset;
    t_read;
    t_write_in_page;
    t_write_cross;
    t_zero;
    t_wrap;
    t_readback;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
    $finish;
  end
endmodule